// File: doc/BRIEF.md
# Floating-Point Single/Double Format Converter

This block moves a floating-point value between the 32-bit single-precision layout and the 64-bit double-precision layout without any arithmetic rounding. It serves the load and store paths of a floating-point unit. A load widens a single into a double. A store narrows a double back into a single.

The conversion copies bit fields and replicates exponent bits. Two cases need more than a copy. A subnormal single is renormalised with a leading-zero count. A double whose exponent is just below the single normal range is shifted right into a single subnormal. Any smaller exponent collapses to a zero that keeps the input sign. The narrowing path simply truncates the bits it drops.

A request is one cycle with `cvt_valid` high. `cvt_widen` selects the direction and `cvt_word` carries the operand. The result appears in a register one clock later, qualified by `res_valid`.

The control is a two-state machine:
- `ST_IDLE`: no result is presented.
- `ST_EMIT`: the result register holds a fresh result.

It has three transitions:
- `GO_EMIT` (`ST_IDLE` to `ST_EMIT`): taken on a valid request.
- `STAY_EMIT`: the machine stays in `ST_EMIT` on a back-to-back request.
- `GO_IDLE` (`ST_EMIT` to `ST_IDLE`): taken when no request arrives.

Top module: `fp_format_converter`

## Requirements
- R1: Widening, exponent field (bits 30:23) all ones: the result is {sign, 11'h7FF, input bits 22:0, 29 zero bits}. The NaN payload, including the quiet bit 22, is kept unchanged.
- R2: Widening, input bits 30:0 at least 0x00800000 with exponent field not all ones: result bits 63:62 are input bits 31:30, and result bits 61:59 are each the inverse of input bit 30. Result bits 58:29 are input bits 29:0, and result bits 28:0 are zero.
- R3: Widening, a nonzero input with bits 30:0 below 0x00800000: the result is the exactly equal normalised double. The biased exponent is 874 plus the position of the highest set bit of the fraction, and the fraction bits below that one are left-aligned in result bits 51:0.
- R4: Widening, bits 30:0 all zero: the result is the input sign in bit 63 with all other bits zero.
- R5: Narrowing, exponent field (bits 62:52) above 896: result bits 31:30 are input bits 63:62 and result bits 29:0 are input bits 58:29. This case includes infinity and NaN.
- R6: Narrowing, exponent from 874 to 896 inclusive: the result is the sign in bit 31 with bits 30:0 equal to ({1, input bits 51:0} >> (926 − exponent)), truncated.
- R7: Narrowing, exponent below 874: the result is a zero carrying the input sign.
- R8: `res_valid` is high in exactly the cycle after each cycle with `cvt_valid` high, and low otherwise. A narrowing result occupies `res_word` bits 31:0 with bits 63:32 zero.
- R9: Reset clears `res_valid` and `res_word`. `res_word` holds its value in every cycle that follows a cycle without a request.
- R10: Widening any non-NaN single and then narrowing the result returns the original single bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cvt_valid | input | 1 | Request strobe, one cycle per conversion |
| cvt_widen | input | 1 | 1 = single to double, 0 = double to single |
| cvt_word | input | 64 | Operand; a single uses bits 31:0 |
| res_valid | output | 1 | Result strobe, one cycle per request |
| res_word | output | 64 | Converted value; a single occupies bits 31:0 |

## Verification
Assertions watch the following on every cycle:
- the handshake timing and that the result holds between requests;
- that the upper half is zero after a narrowing;
- that an all-ones single exponent widens to the double's all-ones exponent;
- that renormalised subnormals land in the exponent window 874 to 896;
- that narrowing below the window or inside it never produces a nonzero single exponent.

Only the bench scenarios can show that the actual bit values are right. These cover:
- signed zeros, the extreme subnormals and normals, infinities, and quiet and signalling NaNs in both directions;
- the exact window edges 873, 874, 896 and 897;
- back-to-back requests;
- that a widening followed by a narrowing returns thousands of non-NaN singles unchanged.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int SP_W      = 32;
    localparam int DP_W      = 64;
    localparam int SP_EXP_W  = 8;
    localparam int DP_EXP_W  = 11;
    localparam int SP_FRAC_W = 23;
    localparam int DP_FRAC_W = 52;
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    // distance between the two fraction fields
    localparam int FRAC_GAP  = DP_FRAC_W - SP_FRAC_W;
    // double exponent that corresponds to single exponent zero
    localparam int REBIAS    = DP_BIAS - SP_BIAS;
    // lowest double exponent that still yields a nonzero single subnormal
    localparam int DEN_LO    = REBIAS - (SP_FRAC_W - 1);
    // right-shift base for the subnormal window
    localparam int DEN_SHIFT_BASE = REBIAS + FRAC_GAP + 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cvt_state_t;
endpackage

// File: rtl/fpc_widen.sv
module fpc_widen
    import fpc_pkg::*;
(
    input  logic [SP_W-1:0] sp_in,
    output logic [DP_W-1:0] dp_out
);
    localparam int MAG_W = SP_W - 1;
    localparam int LZ_W  = $clog2(SP_W) + 1;

    logic [MAG_W-1:0]    mag;
    logic [SP_EXP_W-1:0] sp_exp;
    logic [LZ_W-1:0]     lz;
    logic [LZ_W-1:0]     shamt;
    logic [DP_W-1:0]     base_word;
    logic [DP_W-1:0]     frac_add;

    assign mag    = sp_in[MAG_W-1:0];
    assign sp_exp = sp_in[SP_W-2 -: SP_EXP_W];

    // leading-zero count of the 32-bit magnitude word
    always_comb begin
        lz = LZ_W'(SP_W);
        for (int i = 0; i < SP_W; i++) begin
            if ({1'b0, mag}[i]) lz = LZ_W'(SP_W - 1 - i);
        end
    end

    assign shamt     = lz - LZ_W'(SP_EXP_W);
    assign base_word = {sp_in[SP_W-1], DP_EXP_W'(REBIAS - int'(shamt)), {DP_FRAC_W{1'b0}}};
    assign frac_add  = DP_W'(mag) << (FRAC_GAP + int'(shamt));

    always_comb begin
        if (mag >= MAG_W'(1 << SP_FRAC_W)) begin
            if (&sp_exp) begin
                dp_out = {sp_in[SP_W-1], {DP_EXP_W{1'b1}}, sp_in[SP_FRAC_W-1:0], {FRAC_GAP{1'b0}}};
            end else begin
                dp_out = {sp_in[SP_W-1 -: 2], {3{~sp_in[SP_W-2]}},
                          sp_in[SP_W-3:0], {FRAC_GAP{1'b0}}};
            end
        end else if (mag == '0) begin
            dp_out = {sp_in[SP_W-1], {(DP_W-1){1'b0}}};
        end else begin
            // leading one of the shifted fraction carries into the exponent
            dp_out = base_word + frac_add;
        end
    end

    always_comb begin
        if (&sp_exp) begin
            AST_WIDE_SPECIAL_EXP: assert (&dp_out[DP_W-2 -: DP_EXP_W]) else $error("special exponent lost"); // R1
        end
        if (sp_exp == '0 && mag != '0) begin
            AST_WIDE_DENORM_WINDOW: assert (int'(dp_out[DP_W-2 -: DP_EXP_W]) >= DEN_LO &&
                                            int'(dp_out[DP_W-2 -: DP_EXP_W]) <= REBIAS)
                else $error("renormalised exponent outside window"); // R3
        end
    end
endmodule

// File: rtl/fpc_narrow.sv
module fpc_narrow
    import fpc_pkg::*;
(
    input  logic [DP_W-1:0] dp_in,
    output logic [SP_W-1:0] sp_out
);
    localparam int SH_W = $clog2(DP_FRAC_W + 2);

    logic [DP_EXP_W-1:0]  dp_exp;
    logic [SH_W-1:0]      rshift;
    logic [DP_FRAC_W:0]   mant;
    logic [DP_FRAC_W:0]   mant_sh;

    assign dp_exp  = dp_in[DP_W-2 -: DP_EXP_W];
    assign rshift  = SH_W'(DEN_SHIFT_BASE - int'(dp_exp));
    assign mant    = {1'b1, dp_in[DP_FRAC_W-1:0]};
    assign mant_sh = mant >> rshift;

    always_comb begin
        if (int'(dp_exp) > REBIAS) begin
            sp_out = {dp_in[DP_W-1 -: 2], dp_in[DP_W-6 -: SP_W-2]};
        end else if (int'(dp_exp) >= DEN_LO) begin
            sp_out = {dp_in[DP_W-1], mant_sh[SP_W-2:0]};
        end else begin
            sp_out = {dp_in[DP_W-1], {(SP_W-1){1'b0}}};
        end
    end

    always_comb begin
        if (int'(dp_exp) < DEN_LO) begin
            AST_NARROW_FLUSH: assert (sp_out[SP_W-2:0] == '0) else $error("flush not zero"); // R7
        end
        if (int'(dp_exp) >= DEN_LO && int'(dp_exp) <= REBIAS) begin
            AST_NARROW_DENORM_EXP: assert (sp_out[SP_W-2 -: SP_EXP_W] == '0) else $error("subnormal has exponent"); // R6
        end
    end
endmodule

// File: rtl/fp_format_converter.sv
module fp_format_converter
    import fpc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cvt_valid,
    input  logic            cvt_widen,
    input  logic [DP_W-1:0] cvt_word,
    output logic            res_valid,
    output logic [DP_W-1:0] res_word
);
    cvt_state_t      state, state_nx;
    logic [DP_W-1:0] wide_res;
    logic [SP_W-1:0] narrow_res;

    fpc_widen u_widen (
        .sp_in  (cvt_word[SP_W-1:0]),
        .dp_out (wide_res)
    );

    fpc_narrow u_narrow (
        .dp_in  (cvt_word),
        .sp_out (narrow_res)
    );

    // GO_EMIT, STAY_EMIT, GO_IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cvt_valid)  state_nx = ST_EMIT;
            ST_EMIT: if (!cvt_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_word <= '0;
        end else if (cvt_valid) begin
            res_word <= cvt_widen ? wide_res : {{(DP_W-SP_W){1'b0}}, narrow_res};
        end
    end

    assign res_valid = (state == ST_EMIT);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_valid |=> res_valid) else $error("missing result strobe"); // R8
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cvt_valid |=> !res_valid) else $error("spurious result strobe"); // R8
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cvt_valid |=> $stable(res_word)) else $error("result changed without request"); // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_valid && !cvt_widen) |=> (res_word[DP_W-1:SP_W] == '0)) else $error("upper half dirty"); // R8
endmodule

// File: tb/fp_format_converter_test.sv
module fp_format_converter_test;
    localparam int CLK_P = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cvt_valid = 1'b0;
    logic        cvt_widen = 1'b0;
    logic [63:0] cvt_word = '0;
    logic        res_valid;
    logic [63:0] res_word;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic        exp_valid = 1'b0;
    logic [63:0] exp_word = '0;
    string       exp_tag = "R9";

    fp_format_converter uut (
        .clk(clk), .rst_n(rst_n), .cvt_valid(cvt_valid), .cvt_widen(cvt_widen),
        .cvt_word(cvt_word), .res_valid(res_valid), .res_word(res_word)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [63:0] ref_widen(input logic [31:0] a, output string tag);
        logic [7:0]  e = a[30:23];
        logic [22:0] f = a[22:0];
        int p = 0;
        logic [63:0] fr;
        if (e == 8'hFF) begin
            tag = "R1";
            return {a[31], 11'h7FF, f, 29'd0};
        end else if (e != 0) begin
            tag = "R2";
            return {a[31], 11'(int'(e) + 896), f, 29'd0};
        end else if (f == 0) begin
            tag = "R4";
            return {a[31], 63'd0};
        end
        tag = "R3";
        for (int i = 0; i < 23; i++) if (f[i]) p = i;
        fr = {41'd0, f} << (52 - p);
        return {a[31], 11'(874 + p), fr[51:0]};
    endfunction

    function automatic logic [31:0] ref_narrow(input logic [63:0] d, output string tag);
        int e = int'(d[62:52]);
        logic [63:0] m;
        if (e > 896) begin
            tag = "R5";
            return {d[63:62], d[58:29]};
        end else if (e >= 874) begin
            tag = "R6";
            m = {11'd0, 1'b1, d[51:0]};
            for (int k = 0; k < 926 - e; k++) m = m >> 1;
            return {d[63], m[30:0]};
        end
        tag = "R7";
        return {d[63], 31'd0};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model, one register stage
    always @(posedge clk or negedge rst_n) begin
        string t;
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_word  <= '0;
            exp_tag   <= "R9";
        end else begin
            exp_valid <= cvt_valid;
            if (cvt_valid) begin
                if (cvt_widen) exp_word <= ref_widen(cvt_word[31:0], t);
                else           exp_word <= {32'd0, ref_narrow(cvt_word, t)};
                exp_tag <= t;
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        check("R8", {63'd0, res_valid}, {63'd0, exp_valid});
        check(exp_tag, res_word, exp_word);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic op(input logic widen, input logic [63:0] w, output logic [63:0] r);
        @(posedge clk); #(CLK_P/4);
        cvt_valid = 1'b1; cvt_widen = widen; cvt_word = w;
        @(posedge clk); #(CLK_P/4);
        cvt_valid = 1'b0;
        r = res_word;
    endtask

    task automatic roundtrip(input logic [31:0] s);
        logic [63:0] d, back;
        op(1'b1, {32'd0, s}, d);
        op(1'b0, d, back);
        check("R10", back, {32'd0, s});
    endtask

    initial begin
        logic [63:0] r;
        logic [31:0] lcg = 32'h1234_5678;
        #(CLK_P/4);
        check("R9", res_word, 64'd0);
        check("R9", {63'd0, res_valid}, 64'd0);
        #(3*CLK_P);
        rst_n = 1'b1;

        // widening directed
        op(1'b1, 64'h0000_0000, r); check("R4", r, 64'h0000_0000_0000_0000);
        op(1'b1, 64'h8000_0000, r); check("R4", r, 64'h8000_0000_0000_0000);
        op(1'b1, 64'h0000_0001, r); check("R3", r, 64'h36A0_0000_0000_0000);
        op(1'b1, 64'h007F_FFFF, r); check("R3", r, 64'h380F_FFFF_C000_0000);
        op(1'b1, 64'h8040_0000, r); check("R3", r, 64'hB800_0000_0000_0000);
        op(1'b1, 64'h0080_0000, r); check("R2", r, 64'h3810_0000_0000_0000);
        op(1'b1, 64'h7F7F_FFFF, r); check("R2", r, 64'h47EF_FFFF_E000_0000);
        op(1'b1, 64'hC000_0000, r); check("R2", r, 64'hC000_0000_0000_0000);
        op(1'b1, 64'h7F80_0000, r); check("R1", r, 64'h7FF0_0000_0000_0000);
        op(1'b1, 64'hFF80_0000, r); check("R1", r, 64'hFFF0_0000_0000_0000);
        op(1'b1, 64'h7FC0_0000, r); check("R1", r, 64'h7FF8_0000_0000_0000);
        op(1'b1, 64'h7FA0_0001, r); check("R1", r, 64'h7FF4_0000_2000_0000);

        // narrowing directed
        op(1'b0, 64'h0000_0000_0000_0000, r); check("R7", r, 64'h0);
        op(1'b0, 64'h8000_0000_0000_0000, r); check("R7", r, 64'h8000_0000);
        op(1'b0, 64'h3690_0000_0000_0001, r); check("R7", r, 64'h0);
        op(1'b0, 64'h36A0_0000_0000_0000, r); check("R6", r, 64'h0000_0001);
        op(1'b0, 64'h3800_0000_0000_0000, r); check("R6", r, 64'h0040_0000);
        op(1'b0, 64'hB800_0000_1FFF_FFFF, r); check("R6", r, 64'h8040_0000);
        op(1'b0, 64'h3810_0000_0000_0000, r); check("R5", r, 64'h0080_0000);
        op(1'b0, 64'h3FF0_0000_0000_0000, r); check("R5", r, 64'h3F80_0000);
        op(1'b0, 64'hFFF0_0000_0000_0000, r); check("R5", r, 64'hFF80_0000);
        op(1'b0, 64'h7FF8_0000_0000_0000, r); check("R5", r, 64'h7FC0_0000);
        op(1'b0, 64'h7FF4_0000_0000_0000, r); check("R5", r, 64'h7FA0_0000);

        // back-to-back stream: strobe stays high, model compares each cycle
        @(posedge clk); #(CLK_P/4);
        for (int i = 0; i < 6; i++) begin
            cvt_valid = 1'b1; cvt_widen = i[0]; cvt_word = {lcg, ~lcg};
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            @(posedge clk); #(CLK_P/4);
        end
        cvt_valid = 1'b0;
        @(posedge clk); #(CLK_P/4);
        check("R8", {63'd0, res_valid}, 64'd0);

        // idle input changes leave the result alone
        r = res_word;
        cvt_word = 64'hDEAD_BEEF_0BAD_F00D; cvt_widen = 1'b1;
        @(posedge clk); #(CLK_P/4);
        check("R9", res_word, r);

        // round trip
        roundtrip(32'h0000_0000); roundtrip(32'h8000_0000);
        roundtrip(32'h0000_0001); roundtrip(32'h807F_FFFF);
        roundtrip(32'h0080_0000); roundtrip(32'h7F7F_FFFF);
        roundtrip(32'h7F80_0000); roundtrip(32'hFF80_0000);
        for (int i = 0; i < 3000; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (!(lcg[30:23] == 8'hFF && lcg[22:0] != 0)) roundtrip(lcg);
            else roundtrip({lcg[31:24], 1'b0, lcg[22:0]});
        end

        @(posedge clk); #(CLK_P/4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule